// File: doc/BRIEF.md
# I2C Slave Address-Matching Controller

This block is the receive-side front end of a two-wire serial slave. It runs on a fast system clock that oversamples the serial clock (SCL) and data (SDA) lines. It finds bus start, repeated-start and stop events. It collects the first byte after every start and decides whether this device is being addressed. When the device is addressed, it pulls SDA low for the acknowledge and then moves data in the direction the address byte asks for.

The own address is a 7-bit input. The all-zero broadcast address is also accepted. The single-bit-set byte 0x01 is never accepted, even when the own address is zero. Data frames carry a programmable number of bits, from 1 to 8.

In a master-to-slave transfer, each received frame is presented right-aligned with a one-cycle valid pulse. In a slave-to-master transfer, a transmit byte is taken from an input at the start of every frame, and a pulse marks the cycle in which it is taken. The output enable drives an external open-drain pull-down: 1 means SDA is pulled low.

Top module: `i2c_slave_addr`

## Requirements
- R1: A falling SDA while SCL is high (start) begins address reception from any state, including in the middle of a transfer without a stop (repeated start). The new address byte sets the new direction.
- R2: A rising SDA while SCL is high (stop) returns the controller to idle with `sdaOe` low.
- R3: Address bits arrive MSB first. Bits 7..1 of the address byte are compared with `ownAddr`. On a match, `sdaOe` is high during the ninth SCL pulse, `addrHit` pulses once, and `rdMode` takes bit 0 of the byte (1 = slave sends, 0 = slave receives).
- R4: The address byte 0x00 is acknowledged whatever the value of `ownAddr`.
- R5: The address byte 0x01 is never acknowledged, including when `ownAddr` is 0.
- R6: After an address that is not accepted, `sdaOe` stays low for every SCL pulse until the next start.
- R7: In receive mode, each data frame holds N bits, MSB first. N is `frameBits`; a value of 0 or above 8 counts as 8. Once the N bits have arrived, `rxData` holds them in bits N-1..0 with the upper bits zero, `rxValid` pulses for one cycle, and the slave acknowledges on the next SCL pulse. Frames repeat until a stop or start.
- R8: In send mode, `txByte` is sampled (with a `txTaken` pulse) on the SCL fall that opens each frame. Its low N bits are sent MSB first. `sdaOe` changes only while SCL is low.
- R9: After a sent frame, a low SDA on the following SCL pulse (master acknowledge) starts the next frame. A high SDA ends sending, and `sdaOe` stays low until a stop or start.
- R10: While reset is held, `sdaOe`, `rxValid`, `addrHit`, `txTaken` and `rdMode` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| ownAddr | input | 7 | Own 7-bit slave address |
| frameBits | input | 4 | Data bits per frame (1..8; 0 or above 8 means 8) |
| txByte | input | 8 | Byte to send in slave-to-master frames |
| sdaOe | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |
| rxData | output | 8 | Last received data frame, right-aligned |
| rxValid | output | 1 | One-cycle pulse when `rxData` is updated |
| addrHit | output | 1 | One-cycle pulse when an address is acknowledged |
| rdMode | output | 1 | Direction of the last accepted address (1 = slave sends) |
| txTaken | output | 1 | One-cycle pulse when `txByte` is sampled |

## Verification
The assertions assume a legal bus. The master moves SDA only while SCL is low, except when it makes a start or stop. It never tries a start or stop while the slave is pulling SDA low. Each SCL phase also lasts longer than the synchronizer latency. The bench master satisfies all of this: it holds every SCL phase for twelve system clocks and changes SDA in the middle of the low phase. Its start and stop sequences are always placed in windows where the slave has already released the line.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

  typedef enum logic [3:0] {
    S_IDLE,   // waiting for a start
    S_ADDR,   // shifting address byte
    S_AEND,   // address complete, decide on SCL fall
    S_ACK,    // slave holds acknowledge low
    S_RX,     // shifting a data frame in
    S_REND,   // data frame complete, push and acknowledge
    S_TX,     // shifting a data frame out
    S_TEND,   // last bit out, release on SCL fall
    S_TACK,   // sample master acknowledge
    S_TNEXT,  // load next transmit frame on SCL fall
    S_WAIT    // released, waiting for stop or start
  } state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrFrame;
    logic cntInc;
    logic rxShift;
    logic addrPhase;
    logic txLoad;
    logic txShift;
    logic oeAck;
    logic oeOff;
    logic rxPush;
  } ctl_t;

  // Status from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic sdaBit;
    logic lastBit;
  } sts_t;

endpackage

// File: rtl/i2c_slv_datapath.sv
module i2c_slv_datapath
  import i2c_slv_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AB_W  = ADDR_W + 1,
  localparam int SH_W  = (DATA_W > AB_W) ? DATA_W : AB_W,
  localparam int CNT_W = $clog2(SH_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [CNT_W-1:0]  frameBits,
  input  logic [DATA_W-1:0] txByte,
  input  ctl_t              ctl,
  output sts_t              sts,
  output logic [AB_W-1:0]   addrByte,
  output logic              sdaOe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid
);

  // Line synchronizers, idle-high reset
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= sclIn;
          sdaSync <= sdaIn;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  // Frame length handling
  logic [CNT_W-1:0] dataLen, frameLimit, bitCnt, txPad;
  assign dataLen    = (frameBits == '0 || frameBits > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : frameBits;
  assign frameLimit = ctl.addrPhase ? CNT_W'(AB_W) : dataLen;
  assign txPad      = CNT_W'(DATA_W) - dataLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            bitCnt <= '0;
    else if (ctl.clrFrame) bitCnt <= '0;
    else if (ctl.cntInc)   bitCnt <= bitCnt + CNT_W'(1);
  end

  // Receive shifter
  logic [SH_W-1:0] rxSh;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxSh <= '0;
    else if (ctl.clrFrame) rxSh <= '0;
    else if (ctl.rxShift)  rxSh <= {rxSh[SH_W-2:0], sdaS};
  end
  assign addrByte = rxSh[AB_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= ctl.rxPush;
      if (ctl.rxPush) rxData <= rxSh[DATA_W-1:0];
    end
  end

  // Transmit shifter, frame left-aligned so the MSB always leads
  logic [DATA_W-1:0] txSh, txLoadVal, txShiftVal;
  assign txLoadVal  = txByte << txPad;
  assign txShiftVal = txSh << 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            txSh <= '0;
    else if (ctl.txLoad)  txSh <= txLoadVal;
    else if (ctl.txShift) txSh <= txShiftVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            sdaOe <= 1'b0;
    else if (ctl.oeAck)   sdaOe <= 1'b1;
    else if (ctl.txLoad)  sdaOe <= ~txLoadVal[DATA_W-1];
    else if (ctl.txShift) sdaOe <= ~txShiftVal[DATA_W-1];
    else if (ctl.oeOff)   sdaOe <= 1'b0;
  end

  // Status to control
  always_comb begin
    sts.sclRise  = sclS & ~sclD;
    sts.sclFall  = ~sclS & sclD;
    sts.startDet = sclS & sclD & sdaD & ~sdaS;
    sts.stopDet  = sclS & sclD & ~sdaD & sdaS;
    sts.sdaBit   = sdaS;
    sts.lastBit  = (bitCnt == frameLimit - CNT_W'(1));
  end

  // R8: the pull-down only moves while SCL is low
  a_r8_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !$past(sclS));

  // R2: a stop leaves the line released
  a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    sts.stopDet |=> !sdaOe);

  // R7: valid is a single-cycle strobe
  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R7: bit counter never runs past the widest frame
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(SH_W));

endmodule

// File: rtl/i2c_slv_ctrl.sv
module i2c_slv_ctrl
  import i2c_slv_pkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int AB_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  sts_t              sts,
  input  logic [AB_W-1:0]   addrByte,
  input  logic [ADDR_W-1:0] ownAddr,
  output ctl_t              ctl,
  output logic              addrHit,
  output logic              rdMode,
  output logic              txTaken
);

  state_t state, stateN;
  logic   accept, latchAddr;

  // Broadcast accepted, the 0x01 byte never
  assign accept = (addrByte != AB_W'(1)) &&
                  ((addrByte == '0) || (addrByte[AB_W-1:1] == ownAddr));

  always_comb begin
    ctl       = '0;
    stateN    = state;
    latchAddr = 1'b0;
    if (sts.startDet) begin
      ctl.clrFrame = 1'b1;
      ctl.oeOff    = 1'b1;
      stateN       = S_ADDR;
    end else if (sts.stopDet) begin
      ctl.oeOff = 1'b1;
      stateN    = S_IDLE;
    end else begin
      unique case (state)
        S_ADDR: begin
          ctl.addrPhase = 1'b1;
          if (sts.sclRise) begin
            ctl.rxShift = 1'b1;
            ctl.cntInc  = 1'b1;
            if (sts.lastBit) stateN = S_AEND;
          end
        end
        S_AEND: begin
          ctl.addrPhase = 1'b1;
          if (sts.sclFall) begin
            if (accept) begin
              ctl.oeAck = 1'b1;
              latchAddr = 1'b1;
              stateN    = S_ACK;
            end else begin
              ctl.oeOff = 1'b1;
              stateN    = S_IDLE;
            end
          end
        end
        S_ACK: begin
          if (sts.sclFall) begin
            ctl.clrFrame = 1'b1;
            if (rdMode) begin
              ctl.txLoad = 1'b1;
              stateN     = S_TX;
            end else begin
              ctl.oeOff = 1'b1;
              stateN    = S_RX;
            end
          end
        end
        S_RX: begin
          if (sts.sclRise) begin
            ctl.rxShift = 1'b1;
            ctl.cntInc  = 1'b1;
            if (sts.lastBit) stateN = S_REND;
          end
        end
        S_REND: begin
          if (sts.sclFall) begin
            ctl.rxPush = 1'b1;
            ctl.oeAck  = 1'b1;
            stateN     = S_ACK;
          end
        end
        S_TX: begin
          if (sts.sclRise) begin
            ctl.cntInc = 1'b1;
            if (sts.lastBit) stateN = S_TEND;
          end else if (sts.sclFall) begin
            ctl.txShift = 1'b1;
          end
        end
        S_TEND: begin
          if (sts.sclFall) begin
            ctl.oeOff = 1'b1;
            stateN    = S_TACK;
          end
        end
        S_TACK: begin
          if (sts.sclRise) stateN = sts.sdaBit ? S_WAIT : S_TNEXT;
        end
        S_TNEXT: begin
          if (sts.sclFall) begin
            ctl.clrFrame = 1'b1;
            ctl.txLoad   = 1'b1;
            stateN       = S_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      rdMode  <= 1'b0;
      addrHit <= 1'b0;
      txTaken <= 1'b0;
    end else begin
      state   <= stateN;
      addrHit <= latchAddr;
      txTaken <= ctl.txLoad;
      if (sts.startDet)   rdMode <= 1'b0;
      else if (latchAddr) rdMode <= addrByte[0];
    end
  end

  // R1: any start enters address reception
  a_r1_start_to_addr: assert property (@(posedge clk) disable iff (!rstN)
    sts.startDet |=> state == S_ADDR);

  // R4: broadcast byte is acknowledged
  a_r4_broadcast_ack: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_AEND && sts.sclFall && !sts.startDet && !sts.stopDet && addrByte == '0)
      |-> ctl.oeAck);

  // R5: the 0x01 byte never draws an acknowledge
  a_r5_no_01_ack: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_AEND && ctl.oeAck) |-> addrByte != AB_W'(1));

  // R9: a master not-acknowledge ends sending
  a_r9_nack_ends: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TACK && sts.sclRise && sts.sdaBit && !sts.startDet && !sts.stopDet)
      |=> state == S_WAIT);

endmodule

// File: rtl/i2c_slave_addr.sv
module i2c_slave_addr
  import i2c_slv_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AB_W  = ADDR_W + 1,
  localparam int SH_W  = (DATA_W > AB_W) ? DATA_W : AB_W,
  localparam int CNT_W = $clog2(SH_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [CNT_W-1:0]  frameBits,
  input  logic [DATA_W-1:0] txByte,
  output logic              sdaOe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              addrHit,
  output logic              rdMode,
  output logic              txTaken
);

  ctl_t            ctl;
  sts_t            sts;
  logic [AB_W-1:0] addrByte;

  i2c_slv_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .frameBits(frameBits), .txByte(txByte), .ctl(ctl), .sts(sts),
    .addrByte(addrByte), .sdaOe(sdaOe), .rxData(rxData), .rxValid(rxValid)
  );

  i2c_slv_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sts(sts), .addrByte(addrByte), .ownAddr(ownAddr),
    .ctl(ctl), .addrHit(addrHit), .rdMode(rdMode), .txTaken(txTaken)
  );

endmodule

// File: tb/i2c_slave_addr_tb.sv
module i2c_slave_addr_tb;

  localparam int Q = 6;   // system clocks per quarter SCL period

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN, sclM, sdaM;
  logic [6:0] ownAddr;
  logic [3:0] frameBits;
  logic [7:0] txByte, rxData;
  logic       sdaOe, rxValid, addrHit, rdMode, txTaken, sdaLine;

  assign sdaLine = sdaM & ~sdaOe;

  i2c_slave_addr u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .ownAddr(ownAddr), .frameBits(frameBits), .txByte(txByte),
    .sdaOe(sdaOe), .rxData(rxData), .rxValid(rxValid),
    .addrHit(addrHit), .rdMode(rdMode), .txTaken(txTaken)
  );

  int testCnt = 0, failCnt = 0;
  int rxCnt = 0, hitCnt = 0, txCnt = 0;
  logic [7:0] rxLast = '0;
  bit done = 0;

  always @(negedge clk) if (rstN) begin
    if (rxValid) begin rxCnt++; rxLast = rxData; end
    if (addrHit) hitCnt++;
    if (txTaken) txCnt++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic hw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, output logic s);
    sclM = 1'b0; hw(); sdaM = b; hw(); sclM = 1'b1; hw(); s = sdaLine; hw();
  endtask

  task automatic sendBits(input logic [7:0] v, input int n, output logic [7:0] got);
    logic s;
    got = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sendBit(v[i], s);
      got = {got[6:0], s};
    end
  endtask

  task automatic doStart();
    sclM = 1'b0; hw(); sdaM = 1'b1; hw(); sclM = 1'b1; hw(); sdaM = 1'b0; hw();
  endtask

  task automatic doStop();
    sclM = 1'b0; hw(); sdaM = 1'b0; hw(); sclM = 1'b1; hw(); sdaM = 1'b1; hw(); hw();
  endtask

  // own[27:21] addr[20:13] bits[12:9] data[8:1] ack[0]
  localparam logic [27:0] VEC [10] = '{
    {7'h50, 8'hA0, 4'd8, 8'h3C, 1'b1},  // write, own match
    {7'h50, 8'hA2, 4'd8, 8'h00, 1'b0},  // mismatch
    {7'h50, 8'h00, 4'd8, 8'h96, 1'b1},  // broadcast
    {7'h00, 8'h01, 4'd8, 8'h00, 1'b0},  // 0x01 with own address 0
    {7'h50, 8'hA1, 4'd8, 8'hC5, 1'b1},  // read, 8 bits
    {7'h2A, 8'h54, 4'd5, 8'h13, 1'b1},  // write, 5 bits
    {7'h2A, 8'h55, 4'd3, 8'h06, 1'b1},  // read, 3 bits
    {7'h50, 8'hA0, 4'd0, 8'hE7, 1'b1},  // length 0 counts as 8
    {7'h7F, 8'h00, 4'd1, 8'h01, 1'b1},  // broadcast, 1-bit frame
    {7'h7F, 8'hFE, 4'd8, 8'h81, 1'b1}   // all-ones own address
  };

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      failCnt++;
      testCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic s;
    logic [7:0] got;
    rstN = 1'b0; sclM = 1'b1; sdaM = 1'b1;
    ownAddr = '0; frameBits = 4'd8; txByte = '0;
    repeat (5) @(negedge clk);
    // R10: reset values
    chk("R10 sdaOe", sdaOe, 0);
    chk("R10 rxValid", rxValid, 0);
    chk("R10 addrHit", addrHit, 0);
    chk("R10 rdMode", rdMode, 0);
    chk("R10 txTaken", txTaken, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // Vector table walk
    for (int k = 0; k < 10; k++) begin
      logic [6:0] vOwn;
      logic [7:0] vAddr, vData, mask;
      logic [3:0] vBits;
      logic       vAck;
      int         n, r0, h0, t0;
      string      tag;
      {vOwn, vAddr, vBits, vData, vAck} = VEC[k];
      n    = (vBits == 0 || vBits > 8) ? 8 : int'(vBits);
      mask = 8'((9'd1 << n) - 9'd1);
      ownAddr = vOwn; frameBits = vBits; txByte = vData;
      tag = (vAddr == 8'h00) ? "R4" : (vAddr == 8'h01) ? "R5" : vAck ? "R3" : "R6";
      h0 = hitCnt;
      doStart();
      sendBits(vAddr, 8, got);
      sendBit(1'b1, s);
      chk($sformatf("%s address ack vec%0d", tag, k), !s, vAck);
      if (vAck) begin
        chk($sformatf("R3 hit pulse vec%0d", k), hitCnt - h0, 1);
        chk($sformatf("R3 direction vec%0d", k), rdMode, vAddr[0]);
        if (!vAddr[0]) begin
          r0 = rxCnt;
          sendBits(vData, n, got);
          sendBit(1'b1, s);
          chk($sformatf("R7 data ack vec%0d", k), !s, 1);
          chk($sformatf("R7 valid count vec%0d", k), rxCnt - r0, 1);
          chk($sformatf("R7 rxData vec%0d", k), rxLast, vData & mask);
        end else begin
          t0 = txCnt;
          sendBits(8'hFF, n, got);
          chk($sformatf("R8 sent bits vec%0d", k), got & mask, vData & mask);
          chk($sformatf("R8 tx taken vec%0d", k), txCnt - t0, 1);
          sendBit(1'b1, s);   // master not-acknowledge
        end
      end else begin
        sendBits(8'h00, 8, got);   // data aimed at another device
        sendBits(8'hFF, 8, got);
        sendBit(1'b1, s);
        chk($sformatf("R6 line untouched vec%0d", k), {got, s}, 9'h1FF);
        chk($sformatf("R6 no hit vec%0d", k), hitCnt - h0, 0);
      end
      doStop();
      chk($sformatf("R2 released after stop vec%0d", k), sdaOe, 0);
    end

    // Multi-frame write then repeated start into multi-frame read
    begin
      int r0, t0;
      ownAddr = 7'h33; frameBits = 4'd8; txByte = 8'hA5;
      doStart();
      sendBits(8'h66, 8, got);
      sendBit(1'b1, s);
      chk("R3 write address ack", !s, 1);
      r0 = rxCnt;
      sendBits(8'h11, 8, got); sendBit(1'b1, s);
      chk("R7 first frame ack", !s, 1);
      sendBits(8'h22, 8, got); sendBit(1'b1, s);
      chk("R7 second frame ack", !s, 1);
      chk("R7 two frames received", rxCnt - r0, 2);
      chk("R7 last frame data", rxLast, 8'h22);
      doStart();   // repeated start, no stop
      sendBits(8'h67, 8, got);
      sendBit(1'b1, s);
      chk("R1 repeated start ack", !s, 1);
      chk("R1 new direction", rdMode, 1);
      t0 = txCnt;
      sendBits(8'hFF, 8, got);
      chk("R8 first read frame", got, 8'hA5);
      txByte = 8'h5A;
      sendBit(1'b0, s);   // master acknowledge
      sendBits(8'hFF, 8, got);
      chk("R9 next frame after ack", got, 8'h5A);
      chk("R8 two loads", txCnt - t0, 2);
      sendBit(1'b1, s);   // master not-acknowledge
      sendBits(8'hFF, 8, got);
      chk("R9 released after nack", got, 8'hFF);
      chk("R9 oe low after nack", sdaOe, 0);
      doStop();
      chk("R2 idle after read", sdaOe, 0);
    end

    // Restart in the middle of an address byte
    begin
      int h0;
      ownAddr = 7'h21; frameBits = 4'd8;
      h0 = hitCnt;
      doStart();
      sendBits(8'h0F, 4, got);
      doStart();
      sendBits(8'h42, 8, got);
      sendBit(1'b1, s);
      chk("R1 restart mid address ack", !s, 1);
      chk("R1 restart single hit", hitCnt - h0, 1);
      doStop();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule